// File: doc/BRIEF.md
# Configuration Image Clock-Ratio Detector

This block sits beside a 32-bit configuration image stream and works out, from the image header alone, the clock-to-data ratio that the downstream configuration port must run at. It counts the words that actually cross the link. It takes an encryption field from one fixed header word and a compression flag from a later fixed header word. It then combines the two flags with the configuration width chosen at image start and produces a 2-bit ratio code.

The block only observes the link. A word counts when both `in_valid` and `in_ready` are high in the same cycle. The block never drives back-pressure: the consumer owns `in_ready`, and a cycle with valid high and ready low is a stalled beat that the block ignores. A `start_img` pulse opens a new image. If the image's last word arrives before the compression word has been seen, the block raises a one-cycle error instead of a ratio.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, `ratio_code` is 0, and `ratio_vld` and `hdr_err` are low.
- R2: The image counts as encrypted when bits [3:2] of word index 69 (counted from 0 after `start_img`) are nonzero.
- R3: The image counts as compressed when bit 1 of word index 229 is zero.
- R4: With width select 0 (16-bit), the ratio code is 0 (x1) for a plain image, 1 (x2) for an encrypted-only image and 2 (x4) for any compressed image.
- R5: With width select 1 (32-bit), the ratio code is 0 for a plain image, 2 (x4) for an encrypted-only image and 3 (x8) for any compressed image.
- R6: The width select is sampled only in the `start_img` cycle. Changing it later in the image has no effect on the ratio.
- R7: Only cycles with `in_valid` and `in_ready` both high advance the word index. A transfer in the same cycle as `start_img` is word 0.
- R8: `ratio_vld` is high for exactly one cycle, the cycle after word 229 transfers. `ratio_code` then holds until the next `start_img`, which clears it to 0 in the following cycle.
- R9: A transfer with `in_last` high at a word index below 229 pulses `hdr_err` for one cycle, the cycle after that transfer. In that case no `ratio_vld` is given for the image.
- R10: Transfers after word 229, and transfers before the first `start_img`, produce no `ratio_vld`, no `hdr_err` and no change of `ratio_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_img | input | 1 | One-cycle pulse marking the start of an image |
| width_sel | input | 1 | Configuration width, 1 = 32-bit, 0 = 16-bit; sampled with `start_img` |
| in_valid | input | 1 | Image word valid on the observed link |
| in_ready | input | 1 | Consumer ready on the observed link |
| in_data | input | 32 | Image word |
| in_last | input | 1 | Marks the final word of the image |
| ratio_code | output | 2 | Clock-to-data ratio code, 0=x1 1=x2 2=x4 3=x8 |
| ratio_vld | output | 1 | One-cycle strobe: `ratio_code` has just been set |
| hdr_err | output | 1 | One-cycle strobe: image ended before the header was complete |

## Verification
The hardest case to reach is the one where the index count and back-pressure interact. If a stalled beat that carries a misleading flag value were counted, the ratio would change. To reach it, the stimulus inserts valid-without-ready beats that carry inverted copies of each header word before the real transfers, so a miscount shows up as a wrong code. The stimulus also ends images early, both before and after the encryption word, and feeds a whole image with no start pulse, to reach the error path and the idle path.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

  // Base ratio from the flags, doubled by one code step for the wide port.
  function automatic ratio_e ratio_lookup(input logic enc, input logic cmp,
                                          input logic wide);
    logic [1:0] code;
    if (!enc && !cmp) begin
      code = RATIO_X1;
    end else begin
      code = cmp ? 2'd2 : 2'd1;
      code = code + {1'b0, wide};
    end
    return ratio_e'(code);
  endfunction

endpackage

// File: rtl/hdr_word_index.sv
module hdr_word_index #(
  parameter int SAT_IDX = 230,
  localparam int IDX_W  = $clog2(SAT_IDX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             advance,
  output logic [IDX_W-1:0] idx
);
  localparam logic [IDX_W-1:0] SAT = IDX_W'(SAT_IDX);

  logic [IDX_W-1:0] cnt_q;

  // A beat in the restart cycle is word 0 of the new image.
  assign idx = restart ? '0 : cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= SAT;
    end else if (advance && idx != SAT) begin
      cnt_q <= idx + 1'b1;
    end else if (restart) begin
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1,
  parameter int IDX_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              beat,
  input  logic              last,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  output logic              enc_flag,
  output logic              cmp_now,
  output logic              final_hit,
  output logic              short_hit
);
  localparam logic [IDX_W-1:0] ENC_I = IDX_W'(ENC_IDX);
  localparam logic [IDX_W-1:0] CMP_I = IDX_W'(CMP_IDX);

  logic active_q;
  logic enc_q;
  logic active;
  logic take;

  assign active    = restart | active_q;
  assign take      = beat & active;
  assign cmp_now   = ~data[CMP_BIT];
  assign final_hit = take && idx == CMP_I;
  assign short_hit = take && last && idx < CMP_I;
  assign enc_flag  = enc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      enc_q    <= 1'b0;
    end else begin
      if (final_hit || short_hit) active_q <= 1'b0;
      else if (restart)           active_q <= 1'b1;

      if (take && idx == ENC_I)   enc_q <= |data[ENC_LSB +: ENC_W];
      else if (restart)           enc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hdr_ratio_out.sv
module hdr_ratio_out
  import hdr_ratio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       width_in,
  input  logic       enc_flag,
  input  logic       cmp_now,
  input  logic       final_hit,
  input  logic       short_hit,
  output logic [1:0] code,
  output logic       vld,
  output logic       err
);
  logic   wide_q;
  ratio_e code_q;

  assign code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
      code_q <= RATIO_X1;
      vld    <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (restart) wide_q <= width_in;
      vld <= final_hit;
      err <= short_hit;
      if (final_hit)
        code_q <= ratio_lookup(enc_flag, cmp_now, restart ? width_in : wide_q);
      else if (restart)
        code_q <= RATIO_X1;
    end
  end
endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect #(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_img,
  input  logic              width_sel,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic [1:0]        ratio_code,
  output logic              ratio_vld,
  output logic              hdr_err
);
  localparam int SAT_IDX = CMP_IDX + 1;
  localparam int IDX_W   = $clog2(SAT_IDX + 1);

  logic             beat;
  logic [IDX_W-1:0] idx;
  logic             enc_flag, cmp_now, final_hit, short_hit;

  assign beat = in_valid & in_ready;

  hdr_word_index #(.SAT_IDX(SAT_IDX)) u_idx (
    .clk(clk), .rst_n(rst_n), .restart(start_img), .advance(beat), .idx(idx)
  );

  hdr_flag_capture #(
    .DATA_W(DATA_W), .ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX),
    .ENC_LSB(ENC_LSB), .ENC_W(ENC_W), .CMP_BIT(CMP_BIT), .IDX_W(IDX_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .restart(start_img), .beat(beat),
    .last(in_last), .idx(idx), .data(in_data),
    .enc_flag(enc_flag), .cmp_now(cmp_now),
    .final_hit(final_hit), .short_hit(short_hit)
  );

  hdr_ratio_out u_out (
    .clk(clk), .rst_n(rst_n), .restart(start_img), .width_in(width_sel),
    .enc_flag(enc_flag), .cmp_now(cmp_now),
    .final_hit(final_hit), .short_hit(short_hit),
    .code(ratio_code), .vld(ratio_vld), .err(hdr_err)
  );
endmodule

// File: rtl/hdr_ratio_detect_chk.sv
module hdr_ratio_detect_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_img,
  input logic       width_sel,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic [1:0] ratio_code,
  input logic       ratio_vld,
  input logic       hdr_err
);
  logic wide_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_seen <= 1'b0;
    else if (start_img) wide_seen <= width_sel;
  end

  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_vld |=> !ratio_vld);

  // R9
  err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> !hdr_err);

  // R9
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_vld && hdr_err));

  // R9
  err_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_err) |-> $past(in_valid && in_ready && in_last));

  // R7
  vld_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_vld) |-> $past(in_valid && in_ready));

  // R4
  narrow_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_vld && !wide_seen) |-> ratio_code != 2'd3);

  // R5
  wide_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ratio_vld && wide_seen) |-> ratio_code != 2'd1);

  // R8
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_img && !in_valid) |=> $stable(ratio_code));
endmodule

bind hdr_ratio_detect hdr_ratio_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_img(start_img), .width_sel(width_sel),
  .in_valid(in_valid), .in_ready(in_ready), .in_last(in_last),
  .ratio_code(ratio_code), .ratio_vld(ratio_vld), .hdr_err(hdr_err)
);

// File: tb/hdr_ratio_detect_test.sv
module hdr_ratio_detect_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_img = 1'b0;
  logic        width_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [1:0]  ratio_code;
  logic        ratio_vld;
  logic        hdr_err;

  int n_chk = 0;
  int n_fail = 0;
  int vcnt, ecnt;
  logic [1:0] vcode;

  always #(CLK_PERIOD/2) clk = ~clk;

  hdr_ratio_detect uut (
    .clk(clk), .rst_n(rst_n), .start_img(start_img), .width_sel(width_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_last(in_last), .ratio_code(ratio_code), .ratio_vld(ratio_vld),
    .hdr_err(hdr_err)
  );

  // {width, enc field[1:0], bit1 of word 229, expected code[1:0]}
  localparam logic [5:0] VEC [10] = '{
    {1'b0, 2'd0, 1'b1, 2'd0}, {1'b0, 2'd1, 1'b1, 2'd1},
    {1'b0, 2'd2, 1'b1, 2'd1}, {1'b0, 2'd0, 1'b0, 2'd2},
    {1'b0, 2'd3, 1'b0, 2'd2}, {1'b1, 2'd0, 1'b1, 2'd0},
    {1'b1, 2'd2, 1'b1, 2'd2}, {1'b1, 2'd3, 1'b1, 2'd2},
    {1'b1, 2'd0, 1'b0, 2'd3}, {1'b1, 2'd1, 1'b0, 2'd3}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic observe();
    if (ratio_vld) begin vcnt++; vcode = ratio_code; end
    if (hdr_err) ecnt++;
  endtask

  function automatic logic [31:0] word_for(input int i, input logic [1:0] enc, input logic cb);
    logic [31:0] w;
    w = (i * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    if (i == 69) w[3:2] = enc;
    if (i == 229) w[1] = cb;
    return w;
  endfunction

  task automatic push(input logic [31:0] d, input logic lst, input logic rdy);
    in_valid = 1'b1; in_ready = rdy; in_data = d; in_last = lst;
    @(negedge clk);
    in_valid = 1'b0; in_ready = 1'b0; in_last = 1'b0; start_img = 1'b0;
    observe();
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); observe(); end
  endtask

  task automatic start_img_only(input logic w);
    start_img = 1'b1; width_sel = w;
    @(negedge clk);
    start_img = 1'b0;
    observe();
  endtask

  // merge: raise start_img together with word 0; stall: decoy beats without ready
  task automatic send_image(input logic w, input logic [1:0] enc, input logic cb,
                            input int n, input logic stall, input logic merge,
                            input logic do_start);
    vcnt = 0; ecnt = 0; vcode = 2'd0;
    if (do_start && !merge) start_img_only(w);
    for (int i = 0; i < n; i++) begin
      if (stall && (i % 3 == 0 || i == 69 || i == 229))
        push(~word_for(i, enc, cb), 1'b1, 1'b0);
      if (merge && i == 0) begin start_img = 1'b1; width_sel = w; end
      push(word_for(i, enc, cb), i == n - 1, 1'b1);
    end
    idle(2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ratio_code == 2'd0, "R1 code", ratio_code, 0);
    check(ratio_vld == 1'b0, "R1 vld", ratio_vld, 0);
    check(hdr_err == 1'b0, "R1 err", hdr_err, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: a whole image with no start pulse is ignored
    send_image(1'b1, 2'd1, 1'b0, 230, 1'b0, 1'b0, 1'b0);
    check(vcnt == 0, "R10 no start vld", vcnt, 0);
    check(ecnt == 0, "R10 no start err", ecnt, 0);
    check(ratio_code == 2'd0, "R10 no start code", ratio_code, 0);

    // R2 R3 R4 R5 R7 R8: table walk, odd entries with stalled decoy beats
    for (int v = 0; v < 10; v++) begin
      send_image(VEC[v][5], VEC[v][4:3], VEC[v][2], 230, v[0], 1'b0, 1'b1);
      check(vcnt == 1, "R8 one vld pulse", vcnt, 1);
      check(ecnt == 0, "R9 no err full image", ecnt, 0);
      check(vcode == VEC[v][1:0], VEC[v][5] ? "R5 wide code" : "R4 narrow code",
            vcode, VEC[v][1:0]);
      idle(4);
      check(ratio_code == VEC[v][1:0], "R8 code holds", ratio_code, VEC[v][1:0]);
    end

    // R8: start pulse clears the code
    start_img_only(1'b0);
    check(ratio_code == 2'd0, "R8 start clears", ratio_code, 0);

    // R9: last before word 69, and between 69 and 229
    send_image(1'b1, 2'd1, 1'b0, 50, 1'b0, 1'b0, 1'b1);
    check(ecnt == 1, "R9 short at 49 err", ecnt, 1);
    check(vcnt == 0, "R9 short at 49 vld", vcnt, 0);
    send_image(1'b0, 2'd3, 1'b0, 150, 1'b1, 1'b0, 1'b1);
    check(ecnt == 1, "R9 short at 149 err", ecnt, 1);
    check(vcnt == 0, "R9 short at 149 vld", vcnt, 0);
    check(ratio_code == 2'd0, "R9 short code", ratio_code, 0);

    // R7: beat in the start cycle is word 0
    send_image(1'b1, 2'd2, 1'b1, 230, 1'b0, 1'b1, 1'b1);
    check(vcnt == 1 && vcode == 2'd2, "R7 merged start", vcode, 2);

    // R6: width change after the start pulse is ignored
    vcnt = 0; ecnt = 0;
    start_img_only(1'b0);
    width_sel = 1'b1;
    for (int i = 0; i < 230; i++) push(word_for(i, 2'd1, 1'b1), i == 229, 1'b1);
    idle(2);
    check(vcnt == 1 && vcode == 2'd1, "R6 width sampled at start", vcode, 1);

    // R10: trailing words after 229 are ignored
    send_image(1'b1, 2'd0, 1'b0, 245, 1'b0, 1'b0, 1'b1);
    check(vcnt == 1, "R10 trailing vld", vcnt, 1);
    check(ecnt == 0, "R10 trailing err", ecnt, 0);
    check(ratio_code == 2'd3, "R10 trailing code", ratio_code, 3);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule